// File: doc/BRIEF.md
# Twisted-Pair Collision and Jabber Watchdog

This block sits between a 10 Mb/s twisted-pair line interface and the media access controller. It watches two activity indications, one for transmit and one for receive. It raises a collision signal whenever both are active together. After the overlap ends, the collision signal stays high for a short extension counted in bit times. A bit-time tick input from the port's timing logic paces that extension.

The block also guards the line against a transmitter that never stops. If transmit activity lasts longer than a set limit, the block drops the transmitter enable, sets a sticky jabber flag and forces collision high. It re-enables the transmitter only after the line has stayed quiet for a set release time. Both limits are parameters in clock cycles, so a test bench can scale them down.

A link-pass flag gates the status outputs. While the link has failed, the collision, transmit-status and receive-status outputs are held inactive. A transmit attempt made during that time is reported on two separate indications:
- a loss-of-carrier level that follows the attempt;
- a collision-error pulse at the end of the attempt.

Top module: `tp_coll_jabber`

## Requirements
- R1: When transmit and receive activity are both high and link pass is high at a clock edge, `coll_o` is high in the following cycle.
- R2: Once the overlap ends, `coll_o` stays high until the edge that samples the second `bit_tick_i` pulse seen with no overlap, and is low after that edge; a fresh overlap restarts the two-tick extension.
- R3: When `tx_act_i` is sampled high on JAB_CYC consecutive edges, `tx_en_o` drops and `jab_flag_o` rises after that edge, and `coll_o` is forced high while link pass holds. Any edge that samples `tx_act_i` low restarts the count.
- R4: After a jabber trip, `tx_en_o` returns high and the forced collision ends after UNJAB_CYC consecutive edges that sample `tx_act_i` low. An edge that samples transmit activity in that wait restarts the count from zero.
- R5: `jab_flag_o` holds until an edge that samples `jab_clr_i` high with no trip at that same edge; a trip at the same edge leaves the flag set.
- R6: An edge that samples `link_ok_i` low makes `coll_o`, `xmt_stat_o` and `rcv_stat_o` low in the next cycle, and discards any pending collision extension.
- R7: `carrier_lost_o` is high in the cycle after each edge that samples `tx_act_i` high with `link_ok_i` low, and low otherwise.
- R8: `coll_err_o` is a one-cycle pulse after the edge that samples `tx_act_i` falling, if link failure was sampled at any edge of that transmit attempt.
- R9: During reset `coll_o`, `jab_flag_o`, `carrier_lost_o`, `coll_err_o`, `xmt_stat_o` and `rcv_stat_o` are low and `tx_en_o` is high.
- R10: While link pass holds, `xmt_stat_o` and `rcv_stat_o` follow `tx_act_i` and `rx_act_i` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_act_i | input | 1 | Transmit activity on the line |
| rx_act_i | input | 1 | Receive activity on the line |
| link_ok_i | input | 1 | Link pass flag |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| jab_clr_i | input | 1 | Write-one-to-clear for the jabber flag |
| coll_o | output | 1 | Collision indication |
| tx_en_o | output | 1 | Transmitter enable |
| jab_flag_o | output | 1 | Sticky jabber flag |
| carrier_lost_o | output | 1 | Transmit attempt while link failed |
| coll_err_o | output | 1 | Collision-error pulse at end of a failed-link attempt |
| xmt_stat_o | output | 1 | Transmit status, gated by link |
| rcv_stat_o | output | 1 | Receive status, gated by link |

## Verification
The assertions assume the following about the inputs:
- all inputs are synchronous to `clk_i`;
- `bit_tick_i` and `jab_clr_i` are single-cycle pulses;
- link pass is stable around any check that relies on the forced collision.

The bench drives every input on the falling clock edge and generates ticks only at chosen idle cycles, so each expected edge is known in advance. The extension sweep covers every placement of the two ticks over a small range. The jabber checks run with small limits, so the trip edge and the release edge can be counted exactly. These include runs just below and exactly at the limit.

// File: rtl/tp_cj_pkg.sv
package tp_cj_pkg;
  typedef enum logic {
    JS_RUN  = 1'b0,
    JS_HOLD = 1'b1
  } jab_state_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/cj_coll_ext.sv
module cj_coll_ext #(
  parameter int unsigned EXT_BITS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_act_i,
  input  logic rx_act_i,
  input  logic link_ok_i,
  input  logic bit_tick_i,
  output logic busy_o
);
  localparam int unsigned CW = tp_cj_pkg::cnt_width(EXT_BITS);
  localparam logic [CW-1:0] RELOAD = CW'(EXT_BITS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!link_ok_i) begin
      cnt_q <= '0;
    end else if (tx_act_i && rx_act_i) begin
      cnt_q <= RELOAD;
    end else if (bit_tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cj_jabber.sv
module cj_jabber #(
  parameter int unsigned JAB_CYC   = 6_250_000,
  parameter int unsigned UNJAB_CYC = 62_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_act_i,
  output logic tx_en_o,
  output logic hold_o,
  output logic trip_o
);
  import tp_cj_pkg::*;

  localparam int unsigned MAXC = (JAB_CYC > UNJAB_CYC) ? JAB_CYC : UNJAB_CYC;
  localparam int unsigned CW = cnt_width(MAXC);
  localparam logic [CW-1:0] JAB_LIM   = CW'(JAB_CYC - 1);
  localparam logic [CW-1:0] UNJAB_LIM = CW'(UNJAB_CYC - 1);

  jab_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign trip_o = (state_q == JS_RUN) && tx_act_i && (cnt_q == JAB_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= JS_RUN;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        JS_RUN: begin
          if (!tx_act_i) begin
            cnt_q <= '0;
          end else if (cnt_q == JAB_LIM) begin
            state_q <= JS_HOLD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: begin
          // quiet-time count restarts on any transmit activity
          if (tx_act_i) begin
            cnt_q <= '0;
          end else if (cnt_q == UNJAB_LIM) begin
            state_q <= JS_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      endcase
    end
  end

  assign tx_en_o = (state_q == JS_RUN);
  assign hold_o  = (state_q == JS_HOLD);
endmodule

// File: rtl/cj_link_err.sv
module cj_link_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_act_i,
  input  logic link_ok_i,
  output logic carrier_lost_o,
  output logic coll_err_o
);
  logic fail_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_seen_q    <= 1'b0;
      carrier_lost_o <= 1'b0;
      coll_err_o     <= 1'b0;
    end else begin
      carrier_lost_o <= tx_act_i && !link_ok_i;
      coll_err_o     <= fail_seen_q && !tx_act_i;
      if (!tx_act_i)       fail_seen_q <= 1'b0;
      else if (!link_ok_i) fail_seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tp_coll_jabber.sv
module tp_coll_jabber #(
  parameter int unsigned EXT_BITS  = 2,
  parameter int unsigned JAB_CYC   = 6_250_000,
  parameter int unsigned UNJAB_CYC = 62_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_act_i,
  input  logic rx_act_i,
  input  logic link_ok_i,
  input  logic bit_tick_i,
  input  logic jab_clr_i,
  output logic coll_o,
  output logic tx_en_o,
  output logic jab_flag_o,
  output logic carrier_lost_o,
  output logic coll_err_o,
  output logic xmt_stat_o,
  output logic rcv_stat_o
);
  logic link_q, tx_q, rx_q, flag_q;
  logic ext_busy, jab_hold, jab_trip;

  cj_coll_ext #(.EXT_BITS(EXT_BITS)) u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_act_i  (tx_act_i),
    .rx_act_i  (rx_act_i),
    .link_ok_i (link_ok_i),
    .bit_tick_i(bit_tick_i),
    .busy_o    (ext_busy)
  );

  cj_jabber #(.JAB_CYC(JAB_CYC), .UNJAB_CYC(UNJAB_CYC)) u_jab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_act_i(tx_act_i),
    .tx_en_o (tx_en_o),
    .hold_o  (jab_hold),
    .trip_o  (jab_trip)
  );

  cj_link_err u_lerr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_act_i      (tx_act_i),
    .link_ok_i     (link_ok_i),
    .carrier_lost_o(carrier_lost_o),
    .coll_err_o    (coll_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b0;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      link_q <= link_ok_i;
      tx_q   <= tx_act_i;
      rx_q   <= rx_act_i;
      if (jab_trip)       flag_q <= 1'b1;
      else if (jab_clr_i) flag_q <= 1'b0;
    end
  end

  assign coll_o     = link_q && (ext_busy || jab_hold);
  assign xmt_stat_o = link_q && tx_q;
  assign rcv_stat_o = link_q && rx_q;
  assign jab_flag_o = flag_q;
endmodule

// File: rtl/tp_coll_jabber_chk.sv
module tp_coll_jabber_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_act_i,
  input logic rx_act_i,
  input logic link_ok_i,
  input logic bit_tick_i,
  input logic jab_clr_i,
  input logic coll_o,
  input logic tx_en_o,
  input logic jab_flag_o,
  input logic carrier_lost_o,
  input logic coll_err_o,
  input logic xmt_stat_o,
  input logic rcv_stat_o
);
  a_r1_overlap_collides: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_act_i && rx_act_i && link_ok_i) |=> coll_o);

  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_o && tx_en_o && link_ok_i && !bit_tick_i) |=> coll_o);

  a_r3_trip_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |-> (jab_flag_o && $past(tx_act_i)));

  a_r4_release_when_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(!tx_act_i));

  a_r5_flag_rises_on_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jab_flag_o) |-> $fell(tx_en_o));

  a_r6_link_fail_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_ok_i |=> (!coll_o && !xmt_stat_o && !rcv_stat_o));

  a_r7_carrier_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_act_i && !link_ok_i) |=> carrier_lost_o);

  a_r8_err_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_err_o |=> !coll_err_o);
endmodule

bind tp_coll_jabber tp_coll_jabber_chk chk_i (.*);

// File: tb/tp_coll_jabber_tb_top.sv
module tp_coll_jabber_tb_top;
  localparam int unsigned JAB   = 20;
  localparam int unsigned UNJAB = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_act, rx_act, link_ok, tick, jclr;
  logic coll, tx_en, jflag, lcar, cerr, xst, rst_o;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  tp_coll_jabber #(.EXT_BITS(2), .JAB_CYC(JAB), .UNJAB_CYC(UNJAB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tx_act_i(tx_act), .rx_act_i(rx_act),
    .link_ok_i(link_ok), .bit_tick_i(tick), .jab_clr_i(jclr),
    .coll_o(coll), .tx_en_o(tx_en), .jab_flag_o(jflag),
    .carrier_lost_o(lcar), .coll_err_o(cerr),
    .xmt_stat_o(xst), .rcv_stat_o(rst_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tx_act = 0; rx_act = 0; link_ok = 1; tick = 0; jclr = 0;
    repeat (3) cyc();
    chk("R9 coll", coll, 1'b0);
    chk("R9 tx_en", tx_en, 1'b1);
    chk("R9 flag", jflag, 1'b0);
    chk("R9 lcar", lcar, 1'b0);
    chk("R9 cerr", cerr, 1'b0);
    chk("R9 xmt", xst, 1'b0);
    chk("R9 rcv", rst_o, 1'b0);
    rst_ni = 1'b1;
    cyc();

    // R10 status mirror
    tx_act = 1; cyc();
    chk("R10 xmt", xst, 1'b1); chk("R10 rcv", rst_o, 1'b0); chk("R10 no coll", coll, 1'b0);
    tx_act = 0; rx_act = 1; cyc();
    chk("R10 xmt", xst, 1'b0); chk("R10 rcv", rst_o, 1'b1);
    rx_act = 0; cyc();

    // R1/R2 extension sweep: ticks at idle cycles g1 and g1+g2
    for (int g1 = 0; g1 < 4; g1++) begin
      for (int g2 = 1; g2 < 4; g2++) begin
        for (int ln = 1; ln <= 2; ln++) begin
          tx_act = 1; rx_act = 1;
          for (int k = 0; k < ln; k++) begin
            cyc();
            chk("R1 overlap", coll, 1'b1);
          end
          tx_act = (ln == 2); rx_act = 0;
          for (int i = 0; i < g1 + g2 + 2; i++) begin
            tick = (i == g1) || (i == g1 + g2);
            cyc();
            chk("R2 extension", coll, (i < g1 + g2) ? 1'b1 : 1'b0);
          end
          tick = 0; tx_act = 0; cyc();
        end
      end
    end

    // R2 re-overlap restarts extension
    tx_act = 1; rx_act = 1; cyc();
    rx_act = 0; tick = 1; cyc();
    chk("R2 after one tick", coll, 1'b1);
    tick = 0; rx_act = 1; cyc();
    rx_act = 0; tick = 1; cyc();
    chk("R2 reload first tick", coll, 1'b1);
    cyc();
    chk("R2 reload second tick", coll, 1'b0);
    tick = 0; tx_act = 0; cyc();

    // R3 restart: two runs of JAB-1 separated by one idle cycle
    for (int r = 0; r < 2; r++) begin
      tx_act = 1;
      for (int k = 1; k < JAB; k++) cyc();
      chk("R3 below limit", tx_en, 1'b1);
      tx_act = 0; cyc();
      chk("R3 idle resets", tx_en, 1'b1);
    end
    chk("R3 no flag", jflag, 1'b0);

    // R3 trip at exactly JAB, then R4 release; R5 set wins over clear
    tx_act = 1;
    for (int k = 1; k <= JAB; k++) begin
      jclr = (k == JAB);
      cyc();
      chk("R3 tx_en", tx_en, (k < JAB) ? 1'b1 : 1'b0);
      chk("R3 coll forced", coll, (k < JAB) ? 1'b0 : 1'b1);
      chk("R5 set wins", jflag, (k < JAB) ? 1'b0 : 1'b1);
    end
    jclr = 0;
    tx_act = 0;
    for (int i = 1; i <= UNJAB; i++) begin
      cyc();
      chk("R4 release", tx_en, (i >= UNJAB) ? 1'b1 : 1'b0);
      chk("R4 coll", coll, (i >= UNJAB) ? 1'b0 : 1'b1);
    end
    chk("R5 sticky", jflag, 1'b1);
    jclr = 1; cyc(); jclr = 0;
    chk("R5 clear", jflag, 1'b0);

    // R4 restart: trip with JAB+5, one burst during wait
    tx_act = 1;
    for (int k = 1; k <= JAB + 5; k++) cyc();
    chk("R3 long run tx_en", tx_en, 1'b0);
    tx_act = 0;
    for (int i = 1; i <= 10; i++) cyc();
    tx_act = 1; cyc();
    chk("R4 burst holds", tx_en, 1'b0);
    tx_act = 0;
    for (int i = 1; i <= UNJAB; i++) begin
      cyc();
      chk("R4 restart", tx_en, (i >= UNJAB) ? 1'b1 : 1'b0);
    end
    jclr = 1; cyc(); jclr = 0;

    // R6 link fail gating and extension discard
    tx_act = 1; rx_act = 1; cyc();
    chk("R1 pre", coll, 1'b1);
    tx_act = 0; rx_act = 0; link_ok = 0; cyc();
    chk("R6 coll", coll, 1'b0);
    link_ok = 1; cyc();
    chk("R6 extension discarded", coll, 1'b0);

    // R6/R7/R8 failed-link attempt
    link_ok = 0; tx_act = 1; rx_act = 1; cyc();
    chk("R6 coll", coll, 1'b0); chk("R6 xmt", xst, 1'b0); chk("R6 rcv", rst_o, 1'b0);
    chk("R7 lcar", lcar, 1'b1); chk("R8 no early err", cerr, 1'b0);
    link_ok = 1; rx_act = 0; cyc();
    chk("R7 lcar drops", lcar, 1'b0);
    tx_act = 0; cyc();
    chk("R8 err pulse", cerr, 1'b1);
    cyc();
    chk("R8 err single", cerr, 1'b0);
    tx_act = 1; cyc(); tx_act = 0; cyc();
    chk("R8 no err on good link", cerr, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule